// File: doc/BRIEF.md
# Three-Slot Fetch and Dispatch Unit

This unit is the front end of an in-order, statically scheduled processor with three parallel pipes. It owns the only program counter in the machine. Each cycle it reads one wide instruction word from instruction memory. It cuts that word into three 16-bit slots and hands every slot to its pipe in the same cycle. Slots are never reordered or held back.

The other two pipes keep no counter of their own. When they need an address for a computation, they read the address of the word now on the slot outputs from a shared output. Branch and compare operations live only in the first pipe's slot, so only that pipe reports taken branches. On a taken branch the unit loads the target into the counter and replaces the word already fetched with no-operations in every slot. It also raises a one-cycle flush that all pipes observe.

Instruction memory is assumed to answer combinationally: the word for the presented address is valid in the same cycle. An empty slot carries the no-operation code 16'hF0F0, so a pipe with nothing to do stays idle.

Top module: `fetch_dispatch_unit`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the next state has `imemAddr` = 0, `imemRead` = 0, `flushAll` = 0, `curPc` = 0, and all three slot outputs equal to the no-operation code 16'hF0F0.
- R2: In the first cycle after reset is released, `imemRead` is 1 and `imemAddr` is still 0. The counter does not advance while `imemRead` is low.
- R3: When no taken branch is accepted at an edge and `imemRead` is high, `imemAddr` increases by one, modulo 2^10 (from 1023 it wraps to 0).
- R4: The word read at address A appears on the slots in the following cycle, all three in that same cycle: bits [15:0] on `instrPipe1`, bits [31:16] on `instrPipe2`, bits [47:32] on `instrPipe3`.
- R5: After reset, `curPc` always equals the `imemAddr` of the previous cycle. This is the address of the word on the slots, or of the word that was squashed.
- R6: When `brTaken` is accepted at an edge, in the next cycle `imemAddr` equals `brTarget`, all three slots hold 16'hF0F0, and `flushAll` is 1 for exactly that one cycle.
- R7: A `brTaken` seen while `flushAll` is high is ignored. The counter keeps counting up from the first target.
- R8: A `brTaken` seen while `imemRead` is low (the first cycle after reset) is ignored.
- R9: Reset takes priority over a taken branch at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 10 | Word address to instruction memory (the program counter) |
| imemRead | output | 1 | Read enable to instruction memory |
| imemData | input | 48 | Fetched word, three packed slots |
| brTaken | input | 1 | Taken-branch request from pipe 1 |
| brTarget | input | 10 | Branch target word address |
| instrPipe1 | output | 16 | Slot issued to pipe 1 |
| instrPipe2 | output | 16 | Slot issued to pipe 2 |
| instrPipe3 | output | 16 | Slot issued to pipe 3 |
| curPc | output | 10 | Address of the word now on the slot outputs |
| flushAll | output | 1 | One-cycle flush pulse to all pipes |

## Verification
Two pairs of events can land on the same edge. The first is a taken branch arriving in the flush cycle of a previous branch. The bench holds `brTaken` high for two consecutive cycles with different targets. It then judges that the counter continues from the first target and that the slots carry the first target's word. The second is reset meeting a taken branch. The bench asserts both together and expects the reset state with no flush. A branch request in the very first fetch cycle after reset is also provoked, and must leave the counter at zero.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int NUM_SLOTS = 3;

  typedef struct packed {
    logic fetchEn;   // memory read is active, counter may advance
    logic redirect;  // taken branch accepted this cycle
  } fdStrobe_t;
endpackage

// File: rtl/fd_control.sv
module fd_control
  import fd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      brTaken,
  output fdStrobe_t strobe,
  output logic      readEn,
  output logic      flushAll
);
  logic runEn;
  logic flushReg;
  logic takeBranch;

  // A branch is honoured only when fetch is live and not inside a flush bubble
  assign takeBranch = runEn & brTaken & ~flushReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      runEn    <= 1'b0;
      flushReg <= 1'b0;
    end else begin
      runEn    <= 1'b1;
      flushReg <= takeBranch;
    end
  end

  assign strobe.fetchEn  = runEn;
  assign strobe.redirect = takeBranch;
  assign readEn          = runEn;
  assign flushAll        = flushReg;

  // flush never lasts longer than one cycle
  assert_flush_single_R7: assert property (@(posedge clk) disable iff (rst)
    flushAll |=> !flushAll);

  // no branch is accepted before fetch is live
  assert_no_early_branch_R8: assert property (@(posedge clk) disable iff (rst)
    !readEn |=> !flushAll);
endmodule

// File: rtl/fd_datapath.sv
module fd_datapath
  import fd_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          SLOT_W   = 16,
  parameter logic [15:0] NOP_CODE = 16'hF0F0,
  parameter int          RESET_PC = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  fdStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]           brTarget,
  input  logic [NUM_SLOTS*SLOT_W-1:0] fetchWord,
  output logic [ADDR_W-1:0]           pcOut,
  output logic [ADDR_W-1:0]           issuePc,
  output logic [NUM_SLOTS*SLOT_W-1:0] slotBus
);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
  localparam logic [SLOT_W-1:0] NOP_SLOT = SLOT_W'(NOP_CODE);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] issuePcReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg      <= PC_INIT;
      issuePcReg <= PC_INIT;
    end else if (strobe.redirect) begin
      pcReg      <= brTarget;
      issuePcReg <= pcReg;
    end else if (strobe.fetchEn) begin
      pcReg      <= pcReg + ADDR_W'(1);
      issuePcReg <= pcReg;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    logic [SLOT_W-1:0] slotReg;
    always_ff @(posedge clk) begin
      if (rst || strobe.redirect || !strobe.fetchEn)
        slotReg <= NOP_SLOT;
      else
        slotReg <= fetchWord[s*SLOT_W +: SLOT_W];
    end
    assign slotBus[s*SLOT_W +: SLOT_W] = slotReg;

    // squashed word never reaches a pipe
    assert_slot_squash_R6: assert property (@(posedge clk) disable iff (rst)
      strobe.redirect |=> slotReg == NOP_SLOT);
  end

  assign pcOut   = pcReg;
  assign issuePc = issuePcReg;

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.fetchEn && !strobe.redirect) |=> pcReg == $past(pcReg) + ADDR_W'(1));

  assert_pc_target_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.redirect |=> pcReg == $past(brTarget));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe.fetchEn |=> $stable(pcReg));
endmodule

// File: rtl/fetch_dispatch_unit.sv
module fetch_dispatch_unit
  import fd_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          SLOT_W   = 16,
  parameter logic [15:0] NOP_CODE = 16'hF0F0
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [ADDR_W-1:0]           imemAddr,
  output logic                        imemRead,
  input  logic [NUM_SLOTS*SLOT_W-1:0] imemData,
  input  logic                        brTaken,
  input  logic [ADDR_W-1:0]           brTarget,
  output logic [SLOT_W-1:0]           instrPipe1,
  output logic [SLOT_W-1:0]           instrPipe2,
  output logic [SLOT_W-1:0]           instrPipe3,
  output logic [ADDR_W-1:0]           curPc,
  output logic                        flushAll
);
  fdStrobe_t                   strobe;
  logic [NUM_SLOTS*SLOT_W-1:0] slotBus;

  fd_control uCtrl (
    .clk      (clk),
    .rst      (rst),
    .brTaken  (brTaken),
    .strobe   (strobe),
    .readEn   (imemRead),
    .flushAll (flushAll)
  );

  fd_datapath #(
    .ADDR_W   (ADDR_W),
    .SLOT_W   (SLOT_W),
    .NOP_CODE (NOP_CODE),
    .RESET_PC (0)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .brTarget  (brTarget),
    .fetchWord (imemData),
    .pcOut     (imemAddr),
    .issuePc   (curPc),
    .slotBus   (slotBus)
  );

  assign instrPipe1 = slotBus[0*SLOT_W +: SLOT_W];
  assign instrPipe2 = slotBus[1*SLOT_W +: SLOT_W];
  assign instrPipe3 = slotBus[2*SLOT_W +: SLOT_W];

  // during a flush every pipe sees an empty slot
  assert_flush_nops_R6: assert property (@(posedge clk) disable iff (rst)
    flushAll |-> (instrPipe1 == SLOT_W'(NOP_CODE) && instrPipe2 == SLOT_W'(NOP_CODE)
                  && instrPipe3 == SLOT_W'(NOP_CODE)));

  // shared pc trails the fetch address by one cycle
  assert_cur_pc_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> curPc == $past(imemAddr));
endmodule

// File: tb/fetch_dispatch_unit_test.sv
module fetch_dispatch_unit_test;
  localparam logic [15:0] NOP = 16'hF0F0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  imemAddr;
  logic        imemRead;
  logic [47:0] imemData;
  logic        brTaken = 1'b0;
  logic [9:0]  brTarget = '0;
  logic [15:0] instrPipe1, instrPipe2, instrPipe3;
  logic [9:0]  curPc;
  logic        flushAll;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] slotAt(int k, logic [9:0] a);
    return {4'(k + 1), 2'b00, a};
  endfunction

  assign imemData = {slotAt(2, imemAddr), slotAt(1, imemAddr), slotAt(0, imemAddr)};

  fetch_dispatch_unit uut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemRead(imemRead),
    .imemData(imemData), .brTaken(brTaken), .brTarget(brTarget),
    .instrPipe1(instrPipe1), .instrPipe2(instrPipe2), .instrPipe3(instrPipe3),
    .curPc(curPc), .flushAll(flushAll)
  );

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkSlots(string req, logic [9:0] a);
    chk(req, instrPipe1, slotAt(0, a));
    chk(req, instrPipe2, slotAt(1, a));
    chk(req, instrPipe3, slotAt(2, a));
  endtask

  task automatic chkNops(string req);
    chk(req, {instrPipe3, instrPipe2, instrPipe1}, {NOP, NOP, NOP});
  endtask

  task automatic tReset();
    rst = 1'b1;
    step(); step(); step();
    chk("R1 addr", imemAddr, 0);
    chk("R1 read", imemRead, 0);
    chk("R1 flush", flushAll, 0);
    chk("R1 curPc", curPc, 0);
    chkNops("R1 slots");
  endtask

  task automatic tStartup();
    rst = 1'b0; brTaken = 1'b1; brTarget = 10'd5;
    step();
    chk("R2 read", imemRead, 1);
    chk("R8 addr held", imemAddr, 0);
    chk("R8 no flush", flushAll, 0);
    chkNops("R2 slots");
    brTaken = 1'b0;
    step();
    chk("R3 addr", imemAddr, 1);
    chkSlots("R4 word0", 10'd0);
    chk("R5 curPc", curPc, 0);
    step();
    chk("R3 addr", imemAddr, 2);
    chkSlots("R4 word1", 10'd1);
  endtask

  task automatic tBranch();
    brTaken = 1'b1; brTarget = 10'd100;
    step();
    brTaken = 1'b0;
    chk("R6 addr", imemAddr, 100);
    chk("R6 flush", flushAll, 1);
    chkNops("R6 slots");
    chk("R5 squashed pc", curPc, 2);
    step();
    chk("R6 flush ends", flushAll, 0);
    chkSlots("R4 target word", 10'd100);
    chk("R3 addr", imemAddr, 101);
    chk("R5 curPc", curPc, 100);
  endtask

  task automatic tBackToBack();
    brTaken = 1'b1; brTarget = 10'd200;
    step();
    chk("R6 addr", imemAddr, 200);
    brTarget = 10'd300;
    step();
    brTaken = 1'b0;
    chk("R7 addr", imemAddr, 201);
    chk("R7 flush", flushAll, 0);
    chkSlots("R7 word", 10'd200);
    step();
    chk("R7 addr", imemAddr, 202);
  endtask

  task automatic tWrap();
    brTaken = 1'b1; brTarget = 10'd1023;
    step();
    brTaken = 1'b0;
    chk("R6 addr", imemAddr, 1023);
    step();
    chk("R3 wrap", imemAddr, 0);
    chkSlots("R4 top word", 10'd1023);
    step();
    chk("R3 after wrap", imemAddr, 1);
    chkSlots("R4 word0", 10'd0);
  endtask

  task automatic tResetPriority();
    brTaken = 1'b1; brTarget = 10'd50; rst = 1'b1;
    step();
    brTaken = 1'b0;
    chk("R9 addr", imemAddr, 0);
    chk("R9 flush", flushAll, 0);
    chk("R9 read", imemRead, 0);
    chkNops("R9 slots");
    rst = 1'b0;
    step(); step();
    chk("R9 restart", imemAddr, 1);
  endtask

  initial begin
    tReset();
    tStartup();
    tBranch();
    tBackToBack();
    tWrap();
    tResetPriority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule